// File: doc/BRIEF.md
# Board Control Register File

A memory-mapped control block that sits on a simple 32-bit register bus (address, read strobe, write strobe, write data, read data). Software uses it to light an eight-segment LED bar, to put a short text message on an eight-character display, to drive a general-purpose output byte, to bit-bang a two-wire serial EEPROM link, and to request a board reset.

The display buffer can be loaded one character at a time, or in a single word write that turns a 32-bit value into eight uppercase hexadecimal digits. A reset request is raised only when a fixed key value is written to the reset register, which keeps a stray write from restarting the board. Offsets that decode to nothing read as zero, flag the access for one cycle and change nothing.

Only the low 20 address bits are decoded, so the block answers anywhere inside a 1 MiB window. Read data is registered: it appears in the cycle after the read strobe and holds until the next read.

Top module: `board_ctrl_regs`

## Requirements
- R1: Only bus_addr[19:0] is decoded; the upper 12 address bits have no effect on which register is reached.
- R2: A read of the switch register (offset 0x00010) returns 0, meaning every switch is closed; a write to it is ignored and is not flagged.
- R3: A write to the LED register (offset 0x00100) stores wr_data[7:0] on led_bar; a read returns that byte zero-extended.
- R4: A write to the hex-word register (offset 0x00410) stores eight uppercase ASCII hex digits of wr_data, nibble [31:28] in display position 0 through nibble [3:0] in position 7; position p is disp_text[8p+7:8p].
- R5: Character position p (0..7) is written at offset 0x418 + 8p with wr_data[7:0] and reads back at the same offset; offsets in that range with bits [2:0] not zero are undecoded.
- R6: The I2C output-enable register (0x00B00) keeps 2 bits, the I2C select register (0x00B18) keeps 1 bit and the general-purpose output register (0x00A00) keeps 8 bits; each drives its port and reads back zero-extended.
- R7: A write to the I2C output register (0x00B10) drives i2c_scl from wr_data[1] and i2c_sda from wr_data[0].
- R8: A read of the I2C input register (0x00B08) returns bit 1 = the last written SCL value and bit 0 = the level on i2c_sda_in, upper bits zero.
- R9: After reset the display holds eight spaces (0x20), and led_bar, gp_out, the I2C registers, reset_req, bad_access and rd_data are zero.
- R10: A write of exactly 0x00000042 to the soft-reset register (0x00500) raises reset_req for exactly one cycle, in the cycle after the write; any other value leaves reset_req low.
- R11: A read or write at an undecoded offset raises bad_access for one cycle in the cycle after the access, returns rd_data 0 and changes no register.
- R12: The write-only hex-word and soft-reset registers read as 0, and a write to the read-only I2C input register is ignored; none of these is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address; low 20 bits decoded |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle flag for an undecoded access |
| led_bar | output | 8 | LED bar drive |
| disp_text | output | 64 | Display characters, position p at bits [8p+7:8p] |
| gp_out | output | 8 | General-purpose output byte |
| i2c_oe | output | 2 | I2C output enables |
| i2c_scl | output | 1 | I2C clock line drive |
| i2c_sda | output | 1 | I2C data line drive |
| i2c_sel | output | 1 | I2C bus select |
| i2c_sda_in | input | 1 | SDA level driven by the EEPROM |
| reset_req | output | 1 | One-cycle board reset request |

## Verification
The hardest case to reach from the ports is an access that lands between two character slots or just beside a real register, because it must both raise the flag and provably leave every register alone. The stimulus writes a recognisable value into the LED bar and display first, then hits offsets one word away from decoded ones and reads the old values back. The reset key is probed with a neighbouring value, and the input register is read with the EEPROM data line driven both ways while SCL is held at each level.

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs #(
  parameter int ADDR_W = 20,
  parameter int NCHAR  = 8,
  parameter logic [31:0] RESET_KEY = 32'h0000_0042
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      bus_addr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic             bad_access,
  output logic [7:0]       led_bar,
  output logic [8*NCHAR-1:0] disp_text,
  output logic [7:0]       gp_out,
  output logic [1:0]       i2c_oe,
  output logic             i2c_scl,
  output logic             i2c_sda,
  output logic             i2c_sel,
  input  logic             i2c_sda_in,
  output logic             reset_req
);

  localparam logic [ADDR_W-1:0] OFF_SW    = ADDR_W'('h00010);
  localparam logic [ADDR_W-1:0] OFF_LED   = ADDR_W'('h00100);
  localparam logic [ADDR_W-1:0] OFF_HEX   = ADDR_W'('h00410);
  localparam logic [ADDR_W-1:0] OFF_CHAR  = ADDR_W'('h00418);
  localparam logic [ADDR_W-1:0] OFF_CEND  = OFF_CHAR + ADDR_W'(8 * NCHAR);
  localparam logic [ADDR_W-1:0] OFF_SRST  = ADDR_W'('h00500);
  localparam logic [ADDR_W-1:0] OFF_GPO   = ADDR_W'('h00A00);
  localparam logic [ADDR_W-1:0] OFF_I2OE  = ADDR_W'('h00B00);
  localparam logic [ADDR_W-1:0] OFF_I2IN  = ADDR_W'('h00B08);
  localparam logic [ADDR_W-1:0] OFF_I2OUT = ADDR_W'('h00B10);
  localparam logic [ADDR_W-1:0] OFF_I2SEL = ADDR_W'('h00B18);
  localparam int IDX_W = $clog2(NCHAR);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] coff;
  logic [IDX_W-1:0]  cidx;
  logic hit_sw, hit_led, hit_hex, hit_chr, hit_srst, hit_gpo;
  logic hit_oe, hit_in, hit_out, hit_sel, known;
  logic [7:0] disp_q [NCHAR];
  logic [7:0] hexc   [NCHAR];
  logic [7:0] led_q, gpo_q;
  logic [1:0] oe_q, out_q;
  logic       sel_q;
  logic [31:0] rmux;

  function automatic logic [7:0] to_hex(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'b0, n}) : (8'h37 + {4'b0, n});
  endfunction

  assign off      = bus_addr[ADDR_W-1:0];
  assign coff     = off - OFF_CHAR;
  assign cidx     = coff[IDX_W+2:3];
  assign hit_sw   = off == OFF_SW;
  assign hit_led  = off == OFF_LED;
  assign hit_hex  = off == OFF_HEX;
  assign hit_chr  = (off >= OFF_CHAR) && (off < OFF_CEND) && (off[2:0] == 3'b0);
  assign hit_srst = off == OFF_SRST;
  assign hit_gpo  = off == OFF_GPO;
  assign hit_oe   = off == OFF_I2OE;
  assign hit_in   = off == OFF_I2IN;
  assign hit_out  = off == OFF_I2OUT;
  assign hit_sel  = off == OFF_I2SEL;
  assign known    = hit_sw | hit_led | hit_hex | hit_chr | hit_srst | hit_gpo |
                    hit_oe | hit_in | hit_out | hit_sel;

  for (genvar i = 0; i < NCHAR; i++) begin : g_chr
    assign hexc[i] = to_hex(wr_data[31-4*i -: 4]);
    assign disp_text[8*i +: 8] = disp_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        disp_q[i] <= 8'h20;
      else if (wr_en && hit_hex)
        disp_q[i] <= hexc[i];
      else if (wr_en && hit_chr && cidx == IDX_W'(i))
        disp_q[i] <= wr_data[7:0];
    end
  end

  always_comb begin
    rmux = 32'b0;
    if (hit_led)       rmux = {24'b0, led_q};
    else if (hit_chr)  rmux = {24'b0, disp_q[cidx]};
    else if (hit_gpo)  rmux = {24'b0, gpo_q};
    else if (hit_oe)   rmux = {30'b0, oe_q};
    else if (hit_in)   rmux = {30'b0, out_q[1], i2c_sda_in};
    else if (hit_out)  rmux = {30'b0, out_q};
    else if (hit_sel)  rmux = {31'b0, sel_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q      <= '0;
      gpo_q      <= '0;
      oe_q       <= '0;
      out_q      <= '0;
      sel_q      <= 1'b0;
      reset_req  <= 1'b0;
      bad_access <= 1'b0;
      rd_data    <= '0;
    end else begin
      reset_req  <= wr_en && hit_srst && (wr_data == RESET_KEY);
      bad_access <= (wr_en || rd_en) && !known;
      if (rd_en) rd_data <= rmux;
      if (wr_en) begin
        if (hit_led) led_q <= wr_data[7:0];
        if (hit_gpo) gpo_q <= wr_data[7:0];
        if (hit_oe)  oe_q  <= wr_data[1:0];
        if (hit_out) out_q <= wr_data[1:0];
        if (hit_sel) sel_q <= wr_data[0];
      end
    end
  end

  assign led_bar = led_q;
  assign gp_out  = gpo_q;
  assign i2c_oe  = oe_q;
  assign i2c_scl = out_q[1];
  assign i2c_sda = out_q[0];
  assign i2c_sel = sel_q;

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  a_r10_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(wr_en) && $past(wr_data) == RESET_KEY);

  a_r11_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(wr_en) || $past(rd_en));

  a_r11_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !known) |=> $stable(led_bar) && $stable(disp_text) && $stable(gp_out)
                          && $stable(i2c_oe) && $stable(i2c_sel) && !reset_req);

  a_r11_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !known) |=> rd_data == 32'b0);

  a_r3_led_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_led) |=> led_bar == $past(wr_data[7:0]));

  a_r4_hex_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_hex) |=> ((disp_text[7:0] >= 8'h30 && disp_text[7:0] <= 8'h39) ||
                            (disp_text[7:0] >= 8'h41 && disp_text[7:0] <= 8'h46)));

  a_r7_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_out) |=> i2c_scl == $past(wr_data[1]) && i2c_sda == $past(wr_data[0]));

endmodule

// File: tb/tb_board_ctrl_regs.sv
module tb_board_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        bad_access;
  logic [7:0]  led_bar;
  logic [63:0] disp_text;
  logic [7:0]  gp_out;
  logic [1:0]  i2c_oe;
  logic        i2c_scl, i2c_sda, i2c_sel;
  logic        i2c_sda_in = 1'b0;
  logic        reset_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  board_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .bad_access(bad_access), .led_bar(led_bar),
    .disp_text(disp_text), .gp_out(gp_out), .i2c_oe(i2c_oe), .i2c_scl(i2c_scl),
    .i2c_sda(i2c_sda), .i2c_sel(i2c_sel), .i2c_sda_in(i2c_sda_in), .reset_req(reset_req)
  );

  // {wr, addr[19:0], data, expected read}
  localparam int NV = 18;
  localparam logic [84:0] VEC [NV] = '{
    {1'b1, 20'h00100, 32'h1234_56A5, 32'h0},          // R3
    {1'b0, 20'h00100, 32'h0,         32'h0000_00A5},  // R3
    {1'b1, 20'h00A00, 32'hFFFF_FF3C, 32'h0},          // R6
    {1'b0, 20'h00A00, 32'h0,         32'h0000_003C},  // R6
    {1'b1, 20'h00B00, 32'hFFFF_FFFF, 32'h0},          // R6
    {1'b0, 20'h00B00, 32'h0,         32'h0000_0003},  // R6
    {1'b1, 20'h00B18, 32'hFFFF_FFFE, 32'h0},          // R6
    {1'b0, 20'h00B18, 32'h0,         32'h0000_0000},  // R6
    {1'b1, 20'h00B18, 32'h0000_0003, 32'h0},          // R6
    {1'b0, 20'h00B18, 32'h0,         32'h0000_0001},  // R6
    {1'b0, 20'h00010, 32'h0,         32'h0000_0000},  // R2
    {1'b1, 20'h00410, 32'h0123_ABEF, 32'h0},          // R4
    {1'b0, 20'h00418, 32'h0,         32'h0000_0030},  // R4 pos0 '0'
    {1'b0, 20'h00450, 32'h0,         32'h0000_0046},  // R4 pos7 'F'
    {1'b0, 20'h00430, 32'h0,         32'h0000_0033},  // R4 pos3 '3'
    {1'b0, 20'h00438, 32'h0,         32'h0000_0041},  // R4 pos4 'A'
    {1'b1, 20'h00428, 32'h0001_FF5A, 32'h0},          // R5 pos2
    {1'b0, 20'h00428, 32'h0,         32'h0000_005A}   // R5
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] hexch(input logic [3:0] n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] exp_disp;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 disp", disp_text, {8{8'h20}});
    chk("R9 outs", {led_bar, gp_out, i2c_oe, i2c_scl, i2c_sda, i2c_sel, reset_req, bad_access},
        '0);
    chk("R9 rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][84]) wr({12'h0, VEC[i][83:64]}, VEC[i][63:32]);
      else begin
        rd({12'h0, VEC[i][83:64]});
        chk($sformatf("vector %0d (R2..R6)", i), rd_data, VEC[i][31:0]);
      end
    end

    // R4 full display via port
    wr(32'h0000_0410, 32'h9C5E_07D1);
    for (int p = 0; p < 8; p++) exp_disp[8*p +: 8] = hexch(4'(32'h9C5E_07D1 >> (28 - 4*p)));
    chk("R4 disp port", disp_text, exp_disp);
    // R5 last position by port
    wr(32'h0000_0450, 32'h0000_007A);
    exp_disp[63:56] = 8'h7A;
    chk("R5 disp pos7", disp_text, exp_disp);

    // R1 upper address bits ignored
    wr(32'hFFF0_0100, 32'h0000_0077);
    chk("R1 led", led_bar, 8'h77);
    rd(32'hABC0_0A00);
    chk("R1 gpo read", rd_data, 32'h3C);

    // R7 serial lines
    wr(32'h0000_0B10, 32'h0000_0002);
    chk("R7 scl/sda", {i2c_scl, i2c_sda}, 2'b10);
    wr(32'h0000_0B10, 32'hFFFF_FFFD);
    chk("R7 scl/sda", {i2c_scl, i2c_sda}, 2'b01);

    // R8 input readback
    i2c_sda_in = 1'b0;
    rd(32'h0000_0B08);
    chk("R8 in scl0 sda0", rd_data, 32'h0);
    i2c_sda_in = 1'b1;
    rd(32'h0000_0B08);
    chk("R8 in scl0 sda1", rd_data, 32'h1);
    wr(32'h0000_0B10, 32'h0000_0003);
    i2c_sda_in = 1'b0;
    rd(32'h0000_0B08);
    chk("R8 in scl1 sda0", rd_data, 32'h2);

    // R10 reset key
    wr(32'h0000_0500, 32'h0000_0042);
    chk("R10 pulse", reset_req, 1'b1);
    @(negedge clk);
    chk("R10 pulse end", reset_req, 1'b0);
    wr(32'h0000_0500, 32'h0000_0043);
    chk("R10 wrong key", reset_req, 1'b0);
    wr(32'h0000_0500, 32'h0100_0042);
    chk("R10 wrong upper", reset_req, 1'b0);

    // R11 undecoded accesses
    wr(32'h0000_0104, 32'h0000_0099);
    chk("R11 wr flag", bad_access, 1'b1);
    chk("R11 led kept", led_bar, 8'h77);
    @(negedge clk);
    chk("R11 flag end", bad_access, 1'b0);
    wr(32'h0000_041C, 32'h0000_0055);
    chk("R11 between chars flag", bad_access, 1'b1);
    chk("R11 disp kept", disp_text, exp_disp);
    rd(32'h0000_0101);
    chk("R11 rd zero", rd_data, 32'h0);
    chk("R11 rd flag", bad_access, 1'b1);
    wr(32'h0000_0458, 32'h0000_0031);
    chk("R11 past chars", {bad_access, disp_text}, {1'b1, exp_disp});

    // R12 write-only and read-only registers
    rd(32'h0000_0410);
    chk("R12 hex reads 0", {bad_access, rd_data}, 33'h0);
    rd(32'h0000_0500);
    chk("R12 srst reads 0", {bad_access, rd_data}, 33'h0);
    wr(32'h0000_0B08, 32'h0000_0000);
    chk("R12 in write ignored", {bad_access, i2c_scl, i2c_sda}, 3'b011);
    wr(32'h0000_0010, 32'hFFFF_FFFF);  // R2 switch write ignored
    chk("R2 switch write", bad_access, 1'b0);
    rd(32'h0000_0010);
    chk("R2 switch read", rd_data, 32'h0);

    // R9 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 disp again", disp_text, {8{8'h20}});
    chk("R9 regs again", {led_bar, gp_out, i2c_oe, i2c_scl, i2c_sda, i2c_sel}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule